// File: doc/BRIEF.md
# Four-Channel Packet DMA Engine

This block copies memory from a source region to a destination region on behalf of up to four peripherals. Each channel is set up through a small register port with a source address, a destination address, a word count and an enable bit. A peripheral then holds its request line high. The engine moves one packet of four words at a time for the selected channel. It first fills an internal four-entry FIFO with four reads from the source. It then empties the FIFO with four writes to the destination.

Channels are served one packet at a time and chosen in round-robin order, so a channel that keeps its request high cannot lock out the others. After each packet the channel's addresses move forward by one packet and its count drops by one packet. When the count reaches zero, the channel switches itself off and raises a sticky done flag. Software clears that flag by writing 1 to it. The memory side is one master port with no wait states. Read data returns one cycle after the read is issued.

Top module: `pkt_dma`

## Requirements
- R1: After reset the engine is idle, `mem_req` is low, and every channel register and done flag reads 0.
- R2: A channel is eligible only when its request input is high, its enable is 1 and its count is nonzero. Eligibility is sampled only in an idle cycle, and the first read of the packet is issued in the next cycle.
- R3: Among eligible channels the grant goes to the first one after the last granted channel, in increasing index order with wrap-around. After reset, channel 0 has the highest priority.
- R4: The read phase issues four reads in four consecutive cycles, at source, source+4, source+8 and source+12, with `mem_we` low.
- R5: Read data is taken from `mem_rdata` one cycle after each read. One cycle with `mem_req` low follows the last read. Then four writes are issued in consecutive cycles to destination, destination+4, destination+8 and destination+12, carrying the four read words in the order they were read.
- R6: The cycle after the last write is an idle cycle. The channel's source and destination have each advanced by 16 and its count has dropped by 4, or has dropped to 0 if it was 4 or less.
- R7: When a packet brings the count to 0, the channel's enable becomes 0 and its bit in `irq_done` becomes 1 in the same cycle.
- R8: Writing the status address clears each done flag whose `reg_wdata` bit is 1. Bits written as 0 leave their flag unchanged. A done flag is never cleared any other way.
- R9: Register map. When `reg_addr[4]` is 0, `reg_addr[3:2]` selects the channel and `reg_addr[1:0]` selects the field: 0 source, 1 destination, 2 count (16 bits), 3 control (bit 0 is enable). When `reg_addr[4]` is 1, the status word is selected and holds the done flags in bits 3:0. `reg_rdata` shows the selected register in the same cycle. Writes take effect at the clock edge.
- R10: The internal FIFO is empty whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req | input | 4 | Per-channel transfer request, level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| mem_req | output | 1 | Memory access valid this cycle |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the read |
| irq_done | output | 4 | Sticky per-channel done flags |

## Verification
A grant is decided in the idle cycle, and the first read appears on the memory port in the following cycle. The last read is followed by a single gap cycle, then the writes, and the register updates and the done flag are visible in the cycle after the fourth write. A full packet therefore occupies ten cycles from one idle cycle to the next. A behavioural model updates at each rising edge from the same inputs, and the memory port, `irq_done` and `reg_rdata` are compared against it at every falling edge, so each result is checked in exactly the cycle it is due. Directed readbacks after completion cover the address advance, the count boundary and the write-1-to-clear flags.

// File: rtl/pkt_dma_pkg.sv
package pkt_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_GAP  = 2'd2,
    ST_WR   = 2'd3
  } dma_state_e;

  localparam logic [1:0] FLD_SRC = 2'd0;
  localparam logic [1:0] FLD_DST = 2'd1;
  localparam logic [1:0] FLD_CNT = 2'd2;
  localparam logic [1:0] FLD_CTL = 2'd3;

endpackage

// File: rtl/pkt_dma_rr_arb.sv
module pkt_dma_rr_arb #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          any,
  output logic [IW-1:0] idx
);

  // Scan from farthest to nearest after 'last'; the nearest requester wins.
  always_comb begin
    any = 1'b0;
    idx = last;
    for (int off = N; off >= 1; off--) begin
      int cand;
      cand = (int'(last) + off) % N;
      if (req[cand]) begin
        any = 1'b1;
        idx = cand[IW-1:0];
      end
    end
  end

endmodule

// File: rtl/pkt_dma_fifo.sv
module pkt_dma_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [PW:0]   count
);

  logic [DW-1:0] store_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;

  // Data storage carries no reset.
  always_ff @(posedge clk) begin
    if (push) store_q[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign rdata = store_q[rp_q];

endmodule

// File: rtl/pkt_dma_chregs.sv
module pkt_dma_chregs import pkt_dma_pkg::*; #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 32,
  parameter int unsigned CW  = 16,
  parameter int unsigned PKT = 4,
  parameter int unsigned WB  = 4,
  parameter int unsigned CHW = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sw_we,
  input  logic [CHW-1:0]          sw_ch,
  input  logic [1:0]              sw_fld,
  input  logic [AW-1:0]           sw_wdata,
  input  logic [NCH-1:0]          sw_clr,
  input  logic                    eng_upd,
  input  logic [CHW-1:0]          eng_ch,
  output logic [NCH-1:0][AW-1:0]  src_o,
  output logic [NCH-1:0][AW-1:0]  dst_o,
  output logic [NCH-1:0][CW-1:0]  cnt_o,
  output logic [NCH-1:0]          en_o,
  output logic [NCH-1:0]          done_o
);

  localparam logic [AW-1:0] ADDR_STEP = AW'(PKT * WB);
  localparam logic [CW-1:0] CNT_STEP  = CW'(PKT);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic upd, wr, last_pkt;
    assign upd      = eng_upd && (eng_ch == CHW'(g));
    assign wr       = sw_we && (sw_ch == CHW'(g));
    assign last_pkt = cnt_o[g] <= CNT_STEP;

    // Engine update wins over a software write in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_o[g]  <= '0;
        dst_o[g]  <= '0;
        cnt_o[g]  <= '0;
        en_o[g]   <= 1'b0;
        done_o[g] <= 1'b0;
      end else begin
        if (upd)                          src_o[g] <= src_o[g] + ADDR_STEP;
        else if (wr && sw_fld == FLD_SRC) src_o[g] <= sw_wdata;

        if (upd)                          dst_o[g] <= dst_o[g] + ADDR_STEP;
        else if (wr && sw_fld == FLD_DST) dst_o[g] <= sw_wdata;

        if (upd)                          cnt_o[g] <= last_pkt ? '0 : cnt_o[g] - CNT_STEP;
        else if (wr && sw_fld == FLD_CNT) cnt_o[g] <= sw_wdata[CW-1:0];

        if (upd && last_pkt)              en_o[g] <= 1'b0;
        else if (wr && sw_fld == FLD_CTL) en_o[g] <= sw_wdata[0];

        if (upd && last_pkt)              done_o[g] <= 1'b1;
        else if (sw_clr[g])               done_o[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pkt_dma.sv
module pkt_dma import pkt_dma_pkg::*; #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned CW  = 16,
  parameter int unsigned PKT = 4,
  parameter int unsigned CHW = $clog2(NCH),
  parameter int unsigned RAW = CHW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] dma_req,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [AW-1:0]  reg_wdata,
  output logic [AW-1:0]  reg_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic [NCH-1:0] irq_done
);

  localparam int unsigned BW  = $clog2(PKT);
  localparam int unsigned WB  = DW / 8;
  localparam int unsigned BSH = $clog2(WB);
  localparam logic [BW-1:0] BEAT_LAST = BW'(PKT - 1);

  dma_state_e state_q, state_d;
  logic [BW-1:0]  beat_q, beat_d;
  logic [CHW-1:0] cur_q, cur_d, last_q, last_d;
  logic           rd_pend_q;
  logic           eng_upd;

  logic [NCH-1:0][AW-1:0] src_v, dst_v;
  logic [NCH-1:0][CW-1:0] cnt_v;
  logic [NCH-1:0]         en_vec, done_vec, cnt_nz, elig;
  logic                   arb_any;
  logic [CHW-1:0]         arb_idx;
  logic [BW:0]            fifo_cnt;
  logic [AW-1:0]          base_addr;

  logic           stat_sel, sw_we;
  logic [NCH-1:0] sw_clr;
  logic [CHW-1:0] rd_ch;
  logic [1:0]     rd_fld;

  // ---------------- register port decode ----------------
  assign stat_sel = reg_addr[RAW-1];
  assign rd_ch    = reg_addr[CHW+1:2];
  assign rd_fld   = reg_addr[1:0];
  assign sw_we    = reg_wr && !stat_sel;
  assign sw_clr   = (reg_wr && stat_sel) ? reg_wdata[NCH-1:0] : '0;

  pkt_dma_chregs #(.NCH(NCH), .AW(AW), .CW(CW), .PKT(PKT), .WB(WB), .CHW(CHW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (sw_we),
    .sw_ch    (rd_ch),
    .sw_fld   (rd_fld),
    .sw_wdata (reg_wdata),
    .sw_clr   (sw_clr),
    .eng_upd  (eng_upd),
    .eng_ch   (cur_q),
    .src_o    (src_v),
    .dst_o    (dst_v),
    .cnt_o    (cnt_v),
    .en_o     (en_vec),
    .done_o   (done_vec)
  );

  always_comb begin
    if (stat_sel) begin
      reg_rdata = AW'(done_vec);
    end else begin
      unique case (rd_fld)
        FLD_SRC: reg_rdata = src_v[rd_ch];
        FLD_DST: reg_rdata = dst_v[rd_ch];
        FLD_CNT: reg_rdata = AW'(cnt_v[rd_ch]);
        default: reg_rdata = AW'(en_vec[rd_ch]);
      endcase
    end
  end

  assign irq_done = done_vec;

  // ---------------- request qualification and arbitration ----------------
  for (genvar g = 0; g < NCH; g++) begin : g_nz
    assign cnt_nz[g] = |cnt_v[g];
  end
  assign elig = dma_req & en_vec & cnt_nz;

  pkt_dma_rr_arb #(.N(NCH), .IW(CHW)) u_arb (
    .req  (elig),
    .last (last_q),
    .any  (arb_any),
    .idx  (arb_idx)
  );

  // ---------------- control state machine ----------------
  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    cur_d   = cur_q;
    last_d  = last_q;
    eng_upd = 1'b0;
    unique case (state_q)
      ST_IDLE: if (arb_any) begin
        state_d = ST_RD;
        beat_d  = '0;
        cur_d   = arb_idx;
        last_d  = arb_idx;
      end
      ST_RD: begin
        beat_d = beat_q + 1'b1;
        if (beat_q == BEAT_LAST) state_d = ST_GAP;
      end
      ST_GAP: state_d = ST_WR;
      default: begin
        beat_d = beat_q + 1'b1;
        if (beat_q == BEAT_LAST) begin
          state_d = ST_IDLE;
          eng_upd = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      beat_q    <= '0;
      cur_q     <= '0;
      last_q    <= CHW'(NCH - 1);
      rd_pend_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      beat_q    <= beat_d;
      cur_q     <= cur_d;
      last_q    <= last_d;
      rd_pend_q <= (state_q == ST_RD);
    end
  end

  // ---------------- master port ----------------
  assign mem_req   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we    = (state_q == ST_WR);
  assign base_addr = mem_we ? dst_v[cur_q] : src_v[cur_q];
  assign mem_addr  = base_addr + (AW'(beat_q) << BSH);

  pkt_dma_fifo #(.DW(DW), .DEPTH(PKT), .PW(BW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rd_pend_q),
    .wdata (mem_rdata),
    .pop   (mem_we),
    .rdata (mem_wdata),
    .count (fifo_cnt)
  );

endmodule

// File: rtl/pkt_dma_chk.sv
module pkt_dma_chk import pkt_dma_pkg::*; #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned AW    = 32,
  parameter int unsigned FCW   = 3,
  parameter int unsigned WSTEP = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [NCH-1:0] irq_done,
  input logic [NCH-1:0] ch_en,
  input logic           reg_wr,
  input logic           stat_sel,
  input logic [NCH-1:0] clr_data,
  input logic [1:0]     state_q,
  input logic [FCW-1:0] fifo_cnt
);

  logic [NCH-1:0] clr_mask;
  assign clr_mask = (reg_wr && stat_sel) ? clr_data : '0;

  a_r10_fifo_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (fifo_cnt == '0));

  a_r4_read_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && $past(mem_req && !mem_we)) |-> (mem_addr == $past(mem_addr) + AW'(WSTEP)));

  a_r5_write_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && $past(mem_req && mem_we)) |-> (mem_addr == $past(mem_addr) + AW'(WSTEP)));

  a_r5_write_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_req && !mem_we) && !mem_req) |=> (mem_req && mem_we));

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(irq_done) & ~$past(clr_mask)) & ~irq_done) == '0));

  a_r7_enable_off_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    (((irq_done & ~$past(irq_done)) & ch_en) == '0));

endmodule

bind pkt_dma pkt_dma_chk #(.NCH(NCH), .AW(AW), .FCW(BW + 1), .WSTEP(DW / 8)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .irq_done (irq_done),
  .ch_en    (en_vec),
  .reg_wr   (reg_wr),
  .stat_sel (reg_addr[RAW-1]),
  .clr_data (reg_wdata[NCH-1:0]),
  .state_q  (state_q),
  .fifo_cnt (fifo_cnt)
);

// File: tb/pkt_dma_tb_top.sv
`timescale 1ns/1ps
module pkt_dma_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  dma_req;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  irq_done;

  int n_cmp = 0;
  int n_bad = 0;
  bit chk_on = 0;
  bit ended  = 0;

  always #2 clk = ~clk;  // 250 MHz

  pkt_dma dut_i (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_done(irq_done)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'hA5C3, a[15:0]};
  endfunction

  // Memory: zero wait, read data one cycle after the address.
  always @(posedge clk) mem_rdata <= pat(mem_addr);

  // ---------------- behavioural reference model ----------------
  int          m_st, m_beat, m_cur, m_last;
  logic [31:0] m_src [4];
  logic [31:0] m_dst [4];
  int          m_cnt [4];
  bit          m_en  [4];
  bit          m_done[4];
  logic [31:0] m_q[$];

  always @(posedge clk) begin
    int pick, c, pre_cnt;
    bit upd;
    logic [31:0] pre_src, pre_dst;
    if (!rst_n) begin
      m_st = 0; m_beat = 0; m_cur = 0; m_last = 3;
      for (int i = 0; i < 4; i++) begin
        m_src[i] = 0; m_dst[i] = 0; m_cnt[i] = 0; m_en[i] = 0; m_done[i] = 0;
      end
      m_q.delete();
    end else begin
      pick = -1;
      upd  = 0;
      if (m_st == 0)
        for (int off = 1; off <= 4; off++) begin
          int k;
          k = (m_last + off) % 4;
          if (pick < 0 && dma_req[k] && m_en[k] && m_cnt[k] != 0) pick = k;
        end
      c = m_cur;
      case (m_st)
        0: if (pick >= 0) begin m_cur = pick; m_last = pick; m_st = 1; m_beat = 0; end
        1: begin
          m_q.push_back(pat(m_src[m_cur] + 32'(4 * m_beat)));
          if (m_beat == 3) begin m_st = 2; m_beat = 0; end else m_beat++;
        end
        2: m_st = 3;
        default: begin
          void'(m_q.pop_front());
          if (m_beat == 3) begin m_st = 0; m_beat = 0; upd = 1; end else m_beat++;
        end
      endcase
      pre_src = m_src[c]; pre_dst = m_dst[c]; pre_cnt = m_cnt[c];
      if (reg_wr) begin
        if (reg_addr[4]) begin
          for (int i = 0; i < 4; i++) if (reg_wdata[i]) m_done[i] = 0;
        end else begin
          case (reg_addr[1:0])
            2'd0: m_src[reg_addr[3:2]] = reg_wdata;
            2'd1: m_dst[reg_addr[3:2]] = reg_wdata;
            2'd2: m_cnt[reg_addr[3:2]] = int'(reg_wdata[15:0]);
            default: m_en[reg_addr[3:2]] = reg_wdata[0];
          endcase
        end
      end
      if (upd) begin
        m_src[c] = pre_src + 32'd16;
        m_dst[c] = pre_dst + 32'd16;
        if (pre_cnt <= 4) begin m_cnt[c] = 0; m_en[c] = 0; m_done[c] = 1; end
        else m_cnt[c] = pre_cnt - 4;
      end
    end
  end

  function automatic logic [31:0] model_rd(input logic [4:0] a);
    if (a[4]) return {28'd0, m_done[3], m_done[2], m_done[1], m_done[0]};
    case (a[1:0])
      2'd0: return m_src[a[3:2]];
      2'd1: return m_dst[a[3:2]];
      2'd2: return 32'(m_cnt[a[3:2]] & 16'hFFFF);
      default: return {31'd0, m_en[a[3:2]]};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) if (chk_on && !ended) begin
    bit exp_req;
    exp_req = (m_st == 1) || (m_st == 3);
    chk((m_st == 0) ? "R6 mem_req idle" : "R2 mem_req", {31'd0, mem_req}, {31'd0, exp_req});
    if (exp_req) begin
      chk("R4 mem_we", {31'd0, mem_we}, {31'd0, m_st == 3});
      if (m_st == 1)
        chk((m_beat == 0) ? "R3 grant/first read addr" : "R4 read addr",
            mem_addr, m_src[m_cur] + 32'(4 * m_beat));
      else begin
        chk("R5 write addr", mem_addr, m_dst[m_cur] + 32'(4 * m_beat));
        chk("R5 write data (R10 FIFO order)", mem_wdata, m_q[0]);
      end
    end
    chk("R7 irq_done", {28'd0, irq_done}, {28'd0, m_done[3], m_done[2], m_done[1], m_done[0]});
    chk("R9 reg_rdata", reg_rdata, model_rd(reg_addr));
  end

  // ---------------- stimulus ----------------
  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic setup_ch(input int ch, input logic [31:0] s, input logic [31:0] d, input int n);
    wr_reg(5'(ch * 4 + 0), s);
    wr_reg(5'(ch * 4 + 1), d);
    wr_reg(5'(ch * 4 + 2), 32'(n));
    wr_reg(5'(ch * 4 + 3), 32'd1);
  endtask

  task automatic rd_expect(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wait_done(input logic [3:0] mask);
    while ((irq_done & mask) != mask) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; dma_req = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_on = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 mem_req after reset", {31'd0, mem_req}, 32'd0);
    chk("R1 irq_done after reset", {28'd0, irq_done}, 32'd0);
    chk("R1 src reg after reset", reg_rdata, 32'd0);
    rd_expect(5'h0A, 32'd0, "R1 count reg after reset");

    // Single channel, two packets.
    setup_ch(0, 32'h0000_1000, 32'h0000_8000, 8);
    @(posedge clk); #1 dma_req = 4'b0001;
    wait_done(4'b0001);
    #1 dma_req = 4'b0000;
    rd_expect(5'h00, 32'h0000_1020, "R6 src advanced by two packets");
    rd_expect(5'h01, 32'h0000_8020, "R6 dst advanced by two packets");
    rd_expect(5'h02, 32'd0, "R6 count reached zero");
    rd_expect(5'h03, 32'd0, "R7 enable cleared at done");

    // R8: zeros leave done set, ones clear it.
    wr_reg(5'h10, 32'h0000_000E);
    rd_expect(5'h10, 32'h0000_0001, "R8 zero bit keeps done flag");
    wr_reg(5'h10, 32'h0000_0001);
    rd_expect(5'h10, 32'h0000_0000, "R8 one bit clears done flag");

    // R2: request with enable off moves nothing.
    wr_reg(5'h04, 32'h0000_3000);
    wr_reg(5'h05, 32'h0000_A000);
    wr_reg(5'h06, 32'd8);
    @(posedge clk); #1 dma_req = 4'b0010;
    repeat (30) @(posedge clk);
    rd_expect(5'h06, 32'd8, "R2 disabled channel count unchanged");
    rd_expect(5'h04, 32'h0000_3000, "R2 disabled channel src unchanged");
    #1 dma_req = 4'b0000;

    // R3: all channels compete, round robin; ch2 has a longer job, ch3 a single packet.
    dma_req = 4'b1111;
    setup_ch(1, 32'h0000_2100, 32'h0000_9100, 8);
    setup_ch(0, 32'h0000_2000, 32'h0000_9000, 8);
    setup_ch(2, 32'h0000_2200, 32'h0000_9200, 12);
    setup_ch(3, 32'h0000_2300, 32'h0000_9300, 4);
    wait_done(4'b1111);
    #1 dma_req = 4'b0000;
    rd_expect(5'h0C, 32'h0000_2310, "R6 single packet src +16");
    rd_expect(5'h0E, 32'd0, "R6 count of 4 ends at zero");
    rd_expect(5'h08, 32'h0000_2230, "R6 three packets src +48");
    rd_expect(5'h10, 32'h0000_000F, "R7 all done flags set");

    // R6: count not a multiple of four still ends at zero.
    wr_reg(5'h10, 32'h0000_000F);
    setup_ch(1, 32'h0000_4000, 32'h0000_C000, 6);
    @(posedge clk); #1 dma_req = 4'b0010;
    wait_done(4'b0010);
    #1 dma_req = 4'b0000;
    rd_expect(5'h06, 32'd0, "R6 count below packet size clamps to zero");
    repeat (5) @(posedge clk);
    finish_run();
  end

endmodule